// File: doc/BRIEF.md
# Floppy Controller Command Phase Sequencer

This block sits behind the byte-wide data port of a floppy disk controller and runs the command protocol. It takes a command byte and then the number of parameter bytes that command needs. It then either returns to idle, dispatches a head move, or presents result bytes for the host to read one at a time. An 8-bit status word shows the host when it may exchange a byte, which way the byte goes, whether a command is in progress, and which drives are still moving their heads.

The block handles the commands that only touch controller state. These are drive timing setup, controller configuration, the configuration lock, the identification query, the interrupt status query, perpendicular recording setup and a register dump. For seek and recalibrate, a one-cycle start pulse hands the drive and target cylinder to a separate head-positioning block. That block reports completion with a done pulse and the cylinder it reached. The completion then waits to be collected by an interrupt status query. Sector data transfer and DMA are handled elsewhere.

After each byte it accepts, the block drops its ready flag for a fixed number of cycles, as slow controllers do. A driver therefore has to poll the ready flag before every byte.

Top module: `fdc_phase_seq`

## Requirements
- R1: After reset the status word reads 0x80. Bit 7 is ready (RQM), bit 6 is direction (1 = host reads), bit 5 is non-DMA execution and is always 0 here, bit 4 is command busy (CB), and bits 3..0 are the per-drive seeking flags.
- R2: Every accepted write or read clears RQM for RQM_GAP cycles (default 2). A byte offered while RQM is 0 is ignored. A write accepted while CB = 0 is a command byte, and later writes are its parameters. During the parameter phase the status reads 0x90 once ready.
- R3: The opcode comes from bits 4..0 of the command byte only. Bits 7..5 do not change which command runs, so 0x50 runs the same command as 0x10.
- R4: Opcode 0x10 (identify) takes no parameters. The status reads 0x50 and then 0xD0, and one result byte, 0x90, is available. Reading it clears CB and direction, so the status goes 0x00, 0x00 and then 0x80.
- R5: Opcode 0x14 sets the lock flag to bit 7 of the command byte and returns one byte: 0x10 when locked, 0x00 when unlocked.
- R6: Opcode 0x03 takes two parameter bytes and stores both. It returns no result, so the block goes back to idle.
- R7: Opcode 0x13 takes three parameter bytes and stores the second and third. It returns no result and does not set any seeking flag.
- R8: Opcode 0x12 takes one parameter byte and stores its bits 6..0. It returns no result.
- R9: Opcode 0x0E returns NUM_DRIVES+5 bytes in this order: the cylinder of each drive from drive 0 upward, the two timing-setup bytes, {lock flag, perpendicular bits 6..0}, and then the second and third configuration bytes. All stored values are 0 after reset.
- R10: Opcode 0x0F takes two parameters: the drive in bits 1..0 of the first, and the target cylinder as the second. Opcode 0x07 takes one parameter, the drive. In the cycle after the last parameter is accepted, pos_start is high for exactly one cycle, with pos_drive, pos_cyl (0 for 0x07) and pos_recal (1 for 0x07). In that same cycle CB clears and the drive's seeking flag sets.
- R11: A pos_done pulse clears that drive's seeking flag, records pos_cur_cyl as the drive's cylinder, and marks an interrupt pending. Opcode 0x08 then returns 0x20|drive followed by that cylinder, and clears the pending mark.
- R12: Opcode 0x08 with nothing pending returns the single byte 0x80.
- R13: Any other opcode, including 0x04 and 0x1F, takes no parameters and returns the single byte 0x80.
- R14: A write during the result phase, or a read outside it, changes neither the remaining result bytes nor the phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_wr | input | 1 | Host write strobe for the data port |
| host_wdata | input | 8 | Byte written by the host |
| host_rd | input | 1 | Host read strobe; pops one result byte |
| host_rdata | output | 8 | Result byte at the head of the queue |
| status | output | 8 | Main status word |
| pos_start | output | 1 | One-cycle head move request |
| pos_drive | output | DRV_W | Drive of the head move |
| pos_cyl | output | 8 | Target cylinder |
| pos_recal | output | 1 | Move is a recalibrate to track 0 |
| pos_done | input | 1 | Head move finished |
| pos_done_drive | input | DRV_W | Drive whose move finished |
| pos_cur_cyl | input | 8 | Cylinder reached by that drive |

## Verification
All of the block's outputs are registered, so each response lands in a known cycle. Take a byte accepted at edge N. The phase change, CB, the direction bit, the first result byte and pos_start all appear after edge N. RQM comes back only after edge N+RQM_GAP, and a seeking flag clears after the edge that samples pos_done. The bench drives strobes on falling edges and samples on the falling edge right after the accepting edge. It checks the status word at exactly those offsets. Beyond that, it polls RQM with a bounded loop the way a driver would.

// File: rtl/fdc_seq_pkg.sv
package fdc_seq_pkg;

   typedef enum logic [1:0] {
      PH_CMD,
      PH_PARAM,
      PH_RESULT
   } phase_e;

   typedef enum logic [3:0] {
      K_TIMING,
      K_RECAL,
      K_INTSTAT,
      K_DUMP,
      K_SEEK,
      K_IDENT,
      K_PERP,
      K_CONFIG,
      K_LOCK,
      K_BAD
   } kind_e;

   localparam logic [4:0] OP_TIMING  = 5'h03;
   localparam logic [4:0] OP_RECAL   = 5'h07;
   localparam logic [4:0] OP_INTSTAT = 5'h08;
   localparam logic [4:0] OP_DUMP    = 5'h0E;
   localparam logic [4:0] OP_SEEK    = 5'h0F;
   localparam logic [4:0] OP_IDENT   = 5'h10;
   localparam logic [4:0] OP_PERP    = 5'h12;
   localparam logic [4:0] OP_CONFIG  = 5'h13;
   localparam logic [4:0] OP_LOCK    = 5'h14;

   localparam logic [7:0] BYTE_INVALID = 8'h80;
   localparam logic [7:0] ST0_SEEK_END = 8'h20;

endpackage

// File: rtl/fdc_cmd_decode.sv
module fdc_cmd_decode
   import fdc_seq_pkg::*;
(
   input  logic [4:0] op_bits,
   output kind_e      kind,
   output logic [1:0] n_params
);

   always_comb begin
      kind     = K_BAD;
      n_params = 2'd0;
      case (op_bits)
         OP_TIMING:  begin kind = K_TIMING;  n_params = 2'd2; end
         OP_RECAL:   begin kind = K_RECAL;   n_params = 2'd1; end
         OP_INTSTAT: begin kind = K_INTSTAT; n_params = 2'd0; end
         OP_DUMP:    begin kind = K_DUMP;    n_params = 2'd0; end
         OP_SEEK:    begin kind = K_SEEK;    n_params = 2'd2; end
         OP_IDENT:   begin kind = K_IDENT;   n_params = 2'd0; end
         OP_PERP:    begin kind = K_PERP;    n_params = 2'd1; end
         OP_CONFIG:  begin kind = K_CONFIG;  n_params = 2'd3; end
         OP_LOCK:    begin kind = K_LOCK;    n_params = 2'd0; end
         default:    begin kind = K_BAD;     n_params = 2'd0; end
      endcase
   end

endmodule

// File: rtl/fdc_state_regs.sv
module fdc_state_regs
   import fdc_seq_pkg::*;
#(
   parameter int NUM_DRIVES = 4,
   localparam int DRV_W = (NUM_DRIVES > 1) ? $clog2(NUM_DRIVES) : 1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    fire,
   input  kind_e                   fire_kind,
   input  logic [7:0]              arg0,
   input  logic [7:0]              arg1,
   input  logic [7:0]              arg2,
   input  logic                    lock_val,
   input  logic                    done,
   input  logic [DRV_W-1:0]        done_drive,
   input  logic [7:0]              done_cyl,
   output logic [7:0]              timing_a,
   output logic [7:0]              timing_b,
   output logic [7:0]              cfg_a,
   output logic [7:0]              cfg_b,
   output logic [6:0]              perp,
   output logic                    lock_q,
   output logic [NUM_DRIVES*8-1:0] cyl_flat,
   output logic [NUM_DRIVES-1:0]   seeking,
   output logic                    int_pend,
   output logic [DRV_W-1:0]        int_drive
);

   logic             mv_start;
   logic [DRV_W-1:0] mv_drive;
   logic             int_ack;

   assign mv_start = fire && (fire_kind == K_SEEK || fire_kind == K_RECAL);
   assign mv_drive = arg0[DRV_W-1:0];
   assign int_ack  = fire && (fire_kind == K_INTSTAT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         timing_a <= '0;
         timing_b <= '0;
         cfg_a    <= '0;
         cfg_b    <= '0;
         perp     <= '0;
         lock_q   <= 1'b0;
      end else if (fire) begin
         case (fire_kind)
            K_TIMING: begin timing_a <= arg0; timing_b <= arg1; end
            K_CONFIG: begin cfg_a <= arg1; cfg_b <= arg2; end
            K_PERP:   perp   <= arg0[6:0];
            K_LOCK:   lock_q <= lock_val;
            default:  ;
         endcase
      end
   end

   for (genvar d = 0; d < NUM_DRIVES; d++) begin : g_drive
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            seeking[d]        <= 1'b0;
            cyl_flat[d*8 +: 8] <= '0;
         end else begin
            if (done && done_drive == DRV_W'(d)) begin
               seeking[d]         <= 1'b0;
               cyl_flat[d*8 +: 8] <= done_cyl;
            end else if (mv_start && mv_drive == DRV_W'(d)) begin
               seeking[d] <= 1'b1;
            end
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         int_pend  <= 1'b0;
         int_drive <= '0;
      end else if (done) begin
         int_pend  <= 1'b1;
         int_drive <= done_drive;
      end else if (int_ack) begin
         int_pend  <= 1'b0;
      end
   end

endmodule

// File: rtl/fdc_result_queue.sv
module fdc_result_queue #(
   parameter int DEPTH = 9,
   localparam int LEN_W = $clog2(DEPTH + 1)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               load,
   input  logic [LEN_W-1:0]   load_len,
   input  logic [DEPTH*8-1:0] load_bytes,
   input  logic               pop,
   output logic [7:0]         head,
   output logic               last
);

   logic [7:0]       mem_q [DEPTH];
   logic [LEN_W-1:0] idx_q;
   logic [LEN_W-1:0] len_q;

   for (genvar i = 0; i < DEPTH; i++) begin : g_slot
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)    mem_q[i] <= '0;
         else if (load) mem_q[i] <= load_bytes[i*8 +: 8];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idx_q <= '0;
         len_q <= '0;
      end else if (load) begin
         idx_q <= '0;
         len_q <= load_len;
      end else if (pop) begin
         idx_q <= idx_q + LEN_W'(1);
      end
   end

   always_comb begin
      head = '0;
      for (int i = 0; i < DEPTH; i++) begin
         if (idx_q == LEN_W'(i)) head = mem_q[i];
      end
   end

   assign last = (idx_q + LEN_W'(1) == len_q);

endmodule

// File: rtl/fdc_phase_seq.sv
module fdc_phase_seq
   import fdc_seq_pkg::*;
#(
   parameter int         NUM_DRIVES = 4,
   parameter int         RQM_GAP    = 2,
   parameter logic [7:0] VERSION_ID = 8'h90,
   localparam int DRV_W     = (NUM_DRIVES > 1) ? $clog2(NUM_DRIVES) : 1,
   localparam int RES_DEPTH = NUM_DRIVES + 5,
   localparam int LEN_W     = $clog2(RES_DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             host_wr,
   input  logic [7:0]       host_wdata,
   input  logic             host_rd,
   output logic [7:0]       host_rdata,
   output logic [7:0]       status,
   output logic             pos_start,
   output logic [DRV_W-1:0] pos_drive,
   output logic [7:0]       pos_cyl,
   output logic             pos_recal,
   input  logic             pos_done,
   input  logic [DRV_W-1:0] pos_done_drive,
   input  logic [7:0]       pos_cur_cyl
);

   if (NUM_DRIVES < 1 || NUM_DRIVES > 4) begin : g_bad_drives
      $error("fdc_phase_seq: NUM_DRIVES must be 1..4");
   end
   if (RQM_GAP < 0 || RQM_GAP > 255) begin : g_bad_gap
      $error("fdc_phase_seq: RQM_GAP must be 0..255");
   end

   phase_e     phase_q;
   kind_e      kind_q;
   logic [1:0] need_q, got_q;
   logic [7:0] arg_q [2];
   logic       rdy;

   kind_e      dec_kind;
   logic [1:0] dec_n;

   fdc_cmd_decode u_dec (
      .op_bits  (host_wdata[4:0]),
      .kind     (dec_kind),
      .n_params (dec_n)
   );

   logic acc_wr, acc_rd;
   assign acc_wr = host_wr && rdy && (phase_q != PH_RESULT);
   assign acc_rd = host_rd && rdy && (phase_q == PH_RESULT);

   // Ready gap after each accepted byte
   if (RQM_GAP == 0) begin : g_nogap
      assign rdy = 1'b1;
   end else begin : g_gap
      localparam int GAP_W = $clog2(RQM_GAP + 1);
      logic [GAP_W-1:0] gap_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                gap_q <= '0;
         else if (acc_wr || acc_rd) gap_q <= GAP_W'(RQM_GAP);
         else if (gap_q != '0)      gap_q <= gap_q - GAP_W'(1);
      end
      assign rdy = (gap_q == '0);
   end

   // Command completion
   logic       fire;
   kind_e      fire_kind;
   logic [7:0] eff0, eff1, eff2;

   always_comb begin
      fire      = 1'b0;
      fire_kind = dec_kind;
      if (acc_wr && phase_q == PH_CMD) begin
         fire      = (dec_n == 2'd0);
         fire_kind = dec_kind;
      end else if (acc_wr && phase_q == PH_PARAM) begin
         fire      = (got_q == need_q - 2'd1);
         fire_kind = kind_q;
      end
      eff0 = (got_q == 2'd0) ? host_wdata : arg_q[0];
      eff1 = (got_q == 2'd1) ? host_wdata : arg_q[1];
      eff2 = host_wdata;
   end

   logic [7:0]              timing_a, timing_b, cfg_a, cfg_b;
   logic [6:0]              perp;
   logic                    lock_q;
   logic [NUM_DRIVES*8-1:0] cyl_flat;
   logic [NUM_DRIVES-1:0]   seeking;
   logic                    int_pend;
   logic [DRV_W-1:0]        int_drive;

   fdc_state_regs #(.NUM_DRIVES(NUM_DRIVES)) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .fire       (fire),
      .fire_kind  (fire_kind),
      .arg0       (eff0),
      .arg1       (eff1),
      .arg2       (eff2),
      .lock_val   (host_wdata[7]),
      .done       (pos_done),
      .done_drive (pos_done_drive),
      .done_cyl   (pos_cur_cyl),
      .timing_a   (timing_a),
      .timing_b   (timing_b),
      .cfg_a      (cfg_a),
      .cfg_b      (cfg_b),
      .perp       (perp),
      .lock_q     (lock_q),
      .cyl_flat   (cyl_flat),
      .seeking    (seeking),
      .int_pend   (int_pend),
      .int_drive  (int_drive)
   );

   // Result payload
   logic [RES_DEPTH*8-1:0] res_bytes;
   logic [LEN_W-1:0]       res_len;

   always_comb begin
      res_bytes = '0;
      res_len   = '0;
      case (fire_kind)
         K_IDENT: begin
            res_bytes[7:0] = VERSION_ID;
            res_len        = LEN_W'(1);
         end
         K_LOCK: begin
            res_bytes[7:0] = {3'b000, host_wdata[7], 4'b0000};
            res_len        = LEN_W'(1);
         end
         K_INTSTAT: begin
            if (int_pend) begin
               res_bytes[7:0]  = ST0_SEEK_END | {{(8-DRV_W){1'b0}}, int_drive};
               res_bytes[15:8] = cyl_flat[int_drive*8 +: 8];
               res_len         = LEN_W'(2);
            end else begin
               res_bytes[7:0] = BYTE_INVALID;
               res_len        = LEN_W'(1);
            end
         end
         K_DUMP: begin
            for (int d = 0; d < NUM_DRIVES; d++) begin
               res_bytes[d*8 +: 8] = cyl_flat[d*8 +: 8];
            end
            res_bytes[NUM_DRIVES*8      +: 8] = timing_a;
            res_bytes[(NUM_DRIVES+1)*8  +: 8] = timing_b;
            res_bytes[(NUM_DRIVES+2)*8  +: 8] = {lock_q, perp};
            res_bytes[(NUM_DRIVES+3)*8  +: 8] = cfg_a;
            res_bytes[(NUM_DRIVES+4)*8  +: 8] = cfg_b;
            res_len = LEN_W'(RES_DEPTH);
         end
         K_BAD: begin
            res_bytes[7:0] = BYTE_INVALID;
            res_len        = LEN_W'(1);
         end
         default: ;
      endcase
   end

   logic q_last;

   fdc_result_queue #(.DEPTH(RES_DEPTH)) u_resq (
      .clk        (clk),
      .rst_n      (rst_n),
      .load       (fire && res_len != '0),
      .load_len   (res_len),
      .load_bytes (res_bytes),
      .pop        (acc_rd),
      .head       (host_rdata),
      .last       (q_last)
   );

   // Phase sequencing
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q  <= PH_CMD;
         kind_q   <= K_BAD;
         need_q   <= '0;
         got_q    <= '0;
         arg_q[0] <= '0;
         arg_q[1] <= '0;
      end else begin
         if (acc_wr && phase_q == PH_CMD) begin
            kind_q <= dec_kind;
            need_q <= dec_n;
            got_q  <= '0;
         end else if (acc_wr && phase_q == PH_PARAM) begin
            if (got_q == 2'd0) arg_q[0] <= host_wdata;
            if (got_q == 2'd1) arg_q[1] <= host_wdata;
            got_q <= got_q + 2'd1;
         end

         if (fire) begin
            phase_q <= (res_len != '0) ? PH_RESULT : PH_CMD;
         end else if (acc_wr && phase_q == PH_CMD) begin
            phase_q <= PH_PARAM;
         end else if (acc_rd && q_last) begin
            phase_q <= PH_CMD;
         end
      end
   end

   // Head move dispatch
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pos_start <= 1'b0;
         pos_drive <= '0;
         pos_cyl   <= '0;
         pos_recal <= 1'b0;
      end else begin
         pos_start <= fire && (fire_kind == K_SEEK || fire_kind == K_RECAL);
         if (fire && (fire_kind == K_SEEK || fire_kind == K_RECAL)) begin
            pos_drive <= eff0[DRV_W-1:0];
            pos_recal <= (fire_kind == K_RECAL);
            pos_cyl   <= (fire_kind == K_RECAL) ? 8'h00 : eff1;
         end
      end
   end

   // Status word
   logic [3:0] seek4;
   always_comb begin
      seek4 = '0;
      seek4[NUM_DRIVES-1:0] = seeking;
      status = {rdy, (phase_q == PH_RESULT), 1'b0, (phase_q != PH_CMD), seek4};
   end

endmodule

// File: rtl/fdc_phase_seq_chk.sv
module fdc_phase_seq_chk #(
   parameter int         NUM_DRIVES = 4,
   parameter int         RQM_GAP    = 2,
   parameter logic [7:0] VERSION_ID = 8'h90,
   localparam int DRV_W = (NUM_DRIVES > 1) ? $clog2(NUM_DRIVES) : 1
) (
   input logic             clk,
   input logic             rst_n,
   input logic             host_wr,
   input logic [7:0]       host_wdata,
   input logic [7:0]       host_rdata,
   input logic [7:0]       status,
   input logic             pos_start,
   input logic [DRV_W-1:0] pos_drive
);

   // R4
   dio_needs_cb_chk: assert property (@(posedge clk) disable iff (!rst_n)
      status[6] |-> status[4]);

   // R3 R4
   ident_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (host_wr && status[7] && !status[6] && !status[4] && host_wdata[4:0] == 5'h10)
      |=> (status[6] && host_rdata == VERSION_ID));

   // R13
   unknown_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (host_wr && status[7] && !status[6] && !status[4] && host_wdata == 8'h1F)
      |=> (status[6] && host_rdata == 8'h80));

   // R10
   start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pos_start |=> !pos_start);

   // R10
   start_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pos_start |-> (status[pos_drive] && !status[4]));

   // R1
   ndma_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      status[6] |-> !status[5]);

   if (RQM_GAP > 0) begin : g_gap_chk
      // R2
      ready_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (host_wr && status[7] && !status[6]) |=> !status[7]);
   end

endmodule

bind fdc_phase_seq fdc_phase_seq_chk #(
   .NUM_DRIVES (NUM_DRIVES),
   .RQM_GAP    (RQM_GAP),
   .VERSION_ID (VERSION_ID)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .host_wr    (host_wr),
   .host_wdata (host_wdata),
   .host_rdata (host_rdata),
   .status     (status),
   .pos_start  (pos_start),
   .pos_drive  (pos_drive)
);

// File: tb/tb_fdc_phase_seq.sv
`timescale 1ns/1ps
module tb_fdc_phase_seq;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       host_wr = 1'b0;
   logic [7:0] host_wdata = '0;
   logic       host_rd = 1'b0;
   logic [7:0] host_rdata;
   logic [7:0] status;
   logic       pos_start;
   logic [1:0] pos_drive;
   logic [7:0] pos_cyl;
   logic       pos_recal;
   logic       pos_done = 1'b0;
   logic [1:0] pos_done_drive = '0;
   logic [7:0] pos_cur_cyl = '0;

   int checks = 0;
   int fails  = 0;

   always #2.5 clk = ~clk;

   fdc_phase_seq dut (
      .clk            (clk),
      .rst_n          (rst_n),
      .host_wr        (host_wr),
      .host_wdata     (host_wdata),
      .host_rd        (host_rd),
      .host_rdata     (host_rdata),
      .status         (status),
      .pos_start      (pos_start),
      .pos_drive      (pos_drive),
      .pos_cyl        (pos_cyl),
      .pos_recal      (pos_recal),
      .pos_done       (pos_done),
      .pos_done_drive (pos_done_drive),
      .pos_cur_cyl    (pos_cur_cyl)
   );

   task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual=%02h expected=%02h", tag, act, exp);
      end
   endtask

   task automatic wait_ready(input logic want_dio);
      int n = 0;
      while (!(status[7] && status[6] == want_dio) && n < 64) begin
         @(negedge clk);
         n++;
      end
      if (n == 64) chk("R2 ready timeout", status, {1'b1, want_dio, 6'b0});
   endtask

   task automatic raw_wr(input logic [7:0] b);
      host_wr = 1'b1;
      host_wdata = b;
      @(negedge clk);
      host_wr = 1'b0;
   endtask

   task automatic raw_rd();
      host_rd = 1'b1;
      @(negedge clk);
      host_rd = 1'b0;
   endtask

   task automatic wr_byte(input logic [7:0] b);
      wait_ready(1'b0);
      raw_wr(b);
   endtask

   task automatic rd_byte(output logic [7:0] b);
      wait_ready(1'b1);
      b = host_rdata;
      raw_rd();
   endtask

   task automatic expect_idle(input string tag);
      repeat (3) @(negedge clk);
      chk(tag, status & 8'hF0, 8'h80);
   endtask

   task automatic t_reset();
      chk("R1 reset status", status, 8'h80);
   endtask

   task automatic t_ident();
      logic [7:0] b;
      wr_byte(8'h10);
      chk("R4 status after cmd", status, 8'h50);
      @(negedge clk);
      chk("R2 gap second cycle", status, 8'h50);
      @(negedge clk);
      chk("R4 result ready", status, 8'hD0);
      rd_byte(b);
      chk("R4 ident byte", b, 8'h90);
      chk("R4 idle gap 0", status, 8'h00);
      @(negedge clk);
      chk("R4 idle gap 1", status, 8'h00);
      @(negedge clk);
      chk("R4 idle again", status, 8'h80);
   endtask

   task automatic t_option_bits();
      logic [7:0] b;
      wr_byte(8'h50);
      rd_byte(b);
      chk("R3 option bits ignored", b, 8'h90);
      expect_idle("R3 back to idle");
   endtask

   task automatic t_lock();
      logic [7:0] b;
      wr_byte(8'h94);
      rd_byte(b);
      chk("R5 lock result", b, 8'h10);
      wr_byte(8'h14);
      rd_byte(b);
      chk("R5 unlock result", b, 8'h00);
   endtask

   task automatic t_dump_reset();
      logic [7:0] b;
      wr_byte(8'h0E);
      for (int i = 0; i < 9; i++) begin
         rd_byte(b);
         chk($sformatf("R9 dump reset byte %0d", i), b, 8'h00);
      end
      expect_idle("R9 dump ends idle");
   endtask

   task automatic t_setup();
      logic [7:0] b;
      logic [7:0] exp_d [9];
      wr_byte(8'h03);
      repeat (3) @(negedge clk);
      chk("R2 param phase status", status, 8'h90);
      wr_byte(8'hAF);
      wr_byte(8'h1E);
      expect_idle("R6 timing no result");
      wr_byte(8'h13);
      wr_byte(8'h00);
      wr_byte(8'h57);
      wr_byte(8'h05);
      expect_idle("R7 config no result");
      chk("R7 no seeking flag", status & 8'h0F, 8'h00);
      wr_byte(8'h12);
      wr_byte(8'h83);
      expect_idle("R8 perp no result");
      wr_byte(8'h94);
      rd_byte(b);
      chk("R5 relock", b, 8'h10);
      exp_d = '{8'h00, 8'h00, 8'h00, 8'h00, 8'hAF, 8'h1E, 8'h83, 8'h57, 8'h05};
      wr_byte(8'h0E);
      for (int i = 0; i < 9; i++) begin
         rd_byte(b);
         chk($sformatf("R9 R6 R7 R8 dump byte %0d", i), b, exp_d[i]);
      end
   endtask

   task automatic done_pulse(input logic [1:0] d, input logic [7:0] c);
      pos_done = 1'b1;
      pos_done_drive = d;
      pos_cur_cyl = c;
      @(negedge clk);
      pos_done = 1'b0;
   endtask

   task automatic t_seek();
      logic [7:0] b;
      wr_byte(8'h0F);
      wr_byte(8'h02);
      wr_byte(8'h2A);
      chk("R10 start pulse", {7'b0, pos_start}, 8'h01);
      chk("R10 drive", {6'b0, pos_drive}, 8'h02);
      chk("R10 cylinder", pos_cyl, 8'h2A);
      chk("R10 not recal", {7'b0, pos_recal}, 8'h00);
      chk("R10 CB clear flag set", status & 8'h1F, 8'h04);
      @(negedge clk);
      chk("R10 pulse one cycle", {7'b0, pos_start}, 8'h00);
      wr_byte(8'h08);
      rd_byte(b);
      chk("R12 nothing pending", b, 8'h80);
      expect_idle("R12 single byte");
      chk("R10 flag held", status & 8'h0F, 8'h04);
      done_pulse(2'd2, 8'h2A);
      chk("R11 flag cleared", status & 8'h0F, 8'h00);
      wr_byte(8'h08);
      rd_byte(b);
      chk("R11 st0", b, 8'h22);
      rd_byte(b);
      chk("R11 cylinder", b, 8'h2A);
      wr_byte(8'h08);
      rd_byte(b);
      chk("R11 pending cleared", b, 8'h80);
      wr_byte(8'h07);
      wr_byte(8'h01);
      chk("R10 recal pulse", {7'b0, pos_start}, 8'h01);
      chk("R10 recal drive", {6'b0, pos_drive}, 8'h01);
      chk("R10 recal flag", {7'b0, pos_recal}, 8'h01);
      chk("R10 recal cyl", pos_cyl, 8'h00);
      done_pulse(2'd1, 8'h00);
      wr_byte(8'h08);
      rd_byte(b);
      chk("R11 recal st0", b, 8'h21);
      rd_byte(b);
      chk("R11 recal cyl", b, 8'h00);
      wr_byte(8'h0E);
      for (int i = 0; i < 9; i++) begin
         rd_byte(b);
         if (i < 4) chk($sformatf("R11 dump cyl %0d", i), b, (i == 2) ? 8'h2A : 8'h00);
      end
   endtask

   task automatic t_unknown();
      logic [7:0] b;
      wr_byte(8'h04);
      rd_byte(b);
      chk("R13 opcode 04", b, 8'h80);
      expect_idle("R13 idle after 04");
      wr_byte(8'h1F);
      rd_byte(b);
      chk("R13 opcode 1F", b, 8'h80);
      expect_idle("R13 idle after 1F");
   endtask

   task automatic t_ignored();
      logic [7:0] b;
      wait_ready(1'b0);
      raw_wr(8'h10);
      raw_wr(8'h94);
      wait_ready(1'b1);
      raw_wr(8'h03);
      chk("R14 write in result ignored", status & 8'hF0, 8'hD0);
      rd_byte(b);
      chk("R2 R14 only first cmd ran", b, 8'h90);
      expect_idle("R2 gap write dropped");
      raw_rd();
      chk("R14 read in idle ignored", status, 8'h80);
      wr_byte(8'h0E);
      for (int i = 0; i < 9; i++) begin
         rd_byte(b);
         if (i == 6) chk("R2 lock untouched by dropped write", b, 8'h83);
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_ident();
      t_option_bits();
      t_lock();
      t_dump_reset();
      t_setup();
      t_seek();
      t_unknown();
      t_ignored();
      $display("Result: errors=%0d of %0d checks", fails, checks);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog: run did not finish");
      $display("Result: errors=%0d of %0d checks", fails, checks);
      $finish;
   end

endmodule